// File: doc/BRIEF.md
# Lockable Clock Configuration Register Bank

This block is a small memory-mapped register bank that stores the static settings of a clock generation tree: the oscillator source select, the PLL power and bypass controls, the PLL integer and fractional multiplier, and four divider codes. It drives every setting out as a plain signal and reads back a PLL status word built from a live lock input and a sticky slip flag.

Software reaches the bank over a single-cycle bus. A write takes effect at the clock edge where `bus_we` is high, and reads are combinational from `bus_addr`. A lock register holds one set-once bit per configuration register. A set bit freezes that register against writes, but the register can still be read. Each configuration register also has its own write-spacing guard. After a write to a register is accepted, that register drops any further write for a fixed window. Changing the oscillator source clears the PLL multiplier and the PLL control bits, so the PLL cannot overshoot when its reference switches.

Word address map:

| Addr | Register |
|---|---|
| 0 | lock |
| 1 | source select [1:0] |
| 2 | PLL control: [0] enable, [1] clock-enable |
| 3 | multiplier: [6:0] integer, [9:8] fraction |
| 4 | status: [0] lock input, [1] slip |
| 5 | system divider [5:0] |
| 6 | auxiliary divider [1:0] |
| 7 | clock-out divider [1:0] |
| 8 | low-speed prescaler [2:0] |

Lock bit i guards the register at address i. Bits 1, 2, 3, 5, 6, 7 and 8 exist.

Top module: `clkcfg_bank`

## Requirements
- R1: After reset, the bank holds these values: system divider 2, auxiliary divider 1, clock-out divider 3, low-speed prescaler 2, and every other register 0, including all lock bits.
- R2: The multiplier register stores the integer field in bits 6:0 and the fraction code in bits 9:8, where codes 0 to 3 mean 0, 0.25, 0.5 and 0.75. Every register reads back only its defined bits, and all other bits read as 0.
- R3: Writing 1 to a lock bit sets it. Writing 0 has no effect. A set lock bit clears only on reset. A read of the lock register returns only bit mask 0x01EE.
- R4: While its lock bit is set, a register ignores writes, and reads still return its stored contents.
- R5: An accepted write of a different value to the source select clears the multiplier register and both PLL control bits in the same cycle. A write of the current value to the source select changes neither.
- R6: The slip flag (status bit 1) sets on a `pll_slip_i` pulse only while the PLL clock-enable bit is 1. Once set, it holds until the PLL enable bit goes from 0 to 1.
- R7: Suppose a write to a configuration register is accepted at clock edge t. A write to the same register at edges t+1 through t+69 is lost, and a write at edge t+70 is accepted.
- R8: Each register has its own spacing window, so a write to one register never delays a write to another.
- R9: The bank ignores writes to the status register and to unmapped addresses, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pll_lock_i | input | 1 | PLL locked indication |
| pll_slip_i | input | 1 | PLL slip event |
| osc_sel | output | 2 | Oscillator source select |
| pll_en | output | 1 | PLL power enable |
| pll_clk_en | output | 1 | PLL output used (bypass off) |
| pll_imult | output | 7 | PLL integer multiplier |
| pll_fmult | output | 2 | PLL fraction code |
| sys_div | output | 6 | System divider code |
| aux_div | output | 2 | Auxiliary divider code |
| clkout_div | output | 2 | Clock-out divider code |
| lsp_div | output | 3 | Low-speed prescaler code |

## Verification
The bench builds the bank with its default parameters: a 4-bit address, 16-bit data and a 69-cycle spacing window. With the real window length, the bench can place writes exactly on the last dropped edge (t+69) and the first accepted edge (t+70). It can also overlap windows on two registers to show that they are independent. The default data width leaves bits 15:10 free, so all-ones writes show that reserved bits read as zero.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NREG   = 9;
  localparam int A_LOCK = 0;
  localparam int A_SRC  = 1;
  localparam int A_PLLC = 2;
  localparam int A_MULT = 3;
  localparam int A_STAT = 4;
  localparam int A_SDIV = 5;
  localparam int A_ADIV = 6;
  localparam int A_ODIV = 7;
  localparam int A_LDIV = 8;

  // registers that own a lock bit and a spacing guard
  localparam logic [NREG-1:0] GUARDED = 9'b1_1110_1110;

  localparam int SRC_W  = 2;
  localparam int IM_W   = 7;
  localparam int FM_W   = 2;
  localparam int SDIV_W = 6;
  localparam int ADIV_W = 2;
  localparam int ODIV_W = 2;
  localparam int LDIV_W = 3;

  localparam logic [SDIV_W-1:0] SDIV_RST = 6'd2;
  localparam logic [ADIV_W-1:0] ADIV_RST = 2'd1;
  localparam logic [ODIV_W-1:0] ODIV_RST = 2'd3;
  localparam logic [LDIV_W-1:0] LDIV_RST = 3'd2;

  typedef struct packed {
    logic [FM_W-1:0] fm;
    logic [IM_W-1:0] im;
  } mult_t;

  typedef struct packed {
    logic clk_en;
    logic en;
  } pllc_t;
endpackage

// File: rtl/clkcfg_wguard.sv
module clkcfg_wguard #(
  parameter int GAP = 69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CW'(GAP);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7
  guard_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7
  guard_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R7
  always_comb begin
    if (rst_n) begin
      guard_range_chk: assert (cnt_q <= CW'(GAP));
    end
  end
endmodule

// File: rtl/clkcfg_lock.sv
module clkcfg_lock #(
  parameter int              N    = 9,
  parameter logic [N-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_bits,
  output logic [N-1:0] lock_q
);
  logic [N-1:0] lock_d;

  always_comb begin
    lock_d = lock_q;
    if (set_en)
      lock_d = lock_q | (set_bits & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) == '0));

  // R3
  lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q & ~MASK) == '0));
endmodule

// File: rtl/clkcfg_slip.sv
module clkcfg_slip (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_d,
  input  logic clk_en_q,
  input  logic slip_evt,
  output logic slip_q
);
  logic slip_d;
  logic reenable;

  assign reenable = en_d & ~en_q;

  always_comb begin
    slip_d = slip_q;
    if (reenable)
      slip_d = 1'b0;
    else if (slip_evt && clk_en_q)
      slip_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slip_q <= 1'b0;
    else        slip_q <= slip_d;
  end

  // R6
  slip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slip_q) |-> $past(clk_en_q));

  // R6
  slip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slip_q) |-> $rose(en_q));
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int GAP_CYCLES = 69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pll_lock_i,
  input  logic              pll_slip_i,
  output logic [SRC_W-1:0]  osc_sel,
  output logic              pll_en,
  output logic              pll_clk_en,
  output logic [IM_W-1:0]   pll_imult,
  output logic [FM_W-1:0]   pll_fmult,
  output logic [SDIV_W-1:0] sys_div,
  output logic [ADIV_W-1:0] aux_div,
  output logic [ODIV_W-1:0] clkout_div,
  output logic [LDIV_W-1:0] lsp_div
);
  localparam int MULT_W = IM_W + FM_W;
  localparam int FM_LSB = 8;

  logic [NREG-1:0] wr_hit, acc, busy, lock_q;

  logic [SRC_W-1:0]  src_q, src_d;
  pllc_t             pllc_q, pllc_d;
  mult_t             mult_q, mult_d;
  logic [SDIV_W-1:0] sdiv_q, sdiv_d;
  logic [ADIV_W-1:0] adiv_q, adiv_d;
  logic [ODIV_W-1:0] odiv_q, odiv_d;
  logic [LDIV_W-1:0] ldiv_q, ldiv_d;
  logic              slip_q;
  logic              src_change;

  wire unused_wdata_hi = ^{bus_wdata[DATA_W-1:FM_LSB+FM_W], acc[A_STAT]};

  // address decode and write acceptance
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_hit[i] = bus_we && (bus_addr == ADDR_W'(i));
    if (GUARDED[i]) begin : g_guard
      clkcfg_wguard #(.GAP(GAP_CYCLES)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc[i]),
        .busy  (busy[i])
      );
    end else begin : g_free
      assign busy[i] = 1'b0;
    end
  end

  assign acc = wr_hit & ~busy & ~lock_q;

  clkcfg_lock #(.N(NREG), .MASK(GUARDED)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (acc[A_LOCK]),
    .set_bits (bus_wdata[NREG-1:0]),
    .lock_q   (lock_q)
  );

  // next-state for configuration registers
  always_comb begin
    src_change = acc[A_SRC] && (bus_wdata[SRC_W-1:0] != src_q);
    src_d  = acc[A_SRC]  ? bus_wdata[SRC_W-1:0]  : src_q;
    sdiv_d = acc[A_SDIV] ? bus_wdata[SDIV_W-1:0] : sdiv_q;
    adiv_d = acc[A_ADIV] ? bus_wdata[ADIV_W-1:0] : adiv_q;
    odiv_d = acc[A_ODIV] ? bus_wdata[ODIV_W-1:0] : odiv_q;
    ldiv_d = acc[A_LDIV] ? bus_wdata[LDIV_W-1:0] : ldiv_q;

    pllc_d = pllc_q;
    if (src_change)
      pllc_d = '0;
    else if (acc[A_PLLC])
      pllc_d = pllc_t'(bus_wdata[1:0]);

    mult_d = mult_q;
    if (src_change)
      mult_d = '0;
    else if (acc[A_MULT])
      mult_d = mult_t'({bus_wdata[FM_LSB +: FM_W], bus_wdata[IM_W-1:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pllc_q <= '0;
      mult_q <= '0;
      sdiv_q <= SDIV_RST;
      adiv_q <= ADIV_RST;
      odiv_q <= ODIV_RST;
      ldiv_q <= LDIV_RST;
    end else begin
      src_q  <= src_d;
      pllc_q <= pllc_d;
      mult_q <= mult_d;
      sdiv_q <= sdiv_d;
      adiv_q <= adiv_d;
      odiv_q <= odiv_d;
      ldiv_q <= ldiv_d;
    end
  end

  clkcfg_slip u_slip (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (pllc_q.en),
    .en_d     (pllc_d.en),
    .clk_en_q (pllc_q.clk_en),
    .slip_evt (pll_slip_i),
    .slip_q   (slip_q)
  );

  // combinational read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_LOCK): bus_rdata[NREG-1:0]   = lock_q;
      ADDR_W'(A_SRC):  bus_rdata[SRC_W-1:0]  = src_q;
      ADDR_W'(A_PLLC): bus_rdata[1:0]        = pllc_q;
      ADDR_W'(A_MULT): begin
        bus_rdata[IM_W-1:0]        = mult_q.im;
        bus_rdata[FM_LSB +: FM_W]  = mult_q.fm;
      end
      ADDR_W'(A_STAT): bus_rdata[1:0]        = {slip_q, pll_lock_i};
      ADDR_W'(A_SDIV): bus_rdata[SDIV_W-1:0] = sdiv_q;
      ADDR_W'(A_ADIV): bus_rdata[ADIV_W-1:0] = adiv_q;
      ADDR_W'(A_ODIV): bus_rdata[ODIV_W-1:0] = odiv_q;
      ADDR_W'(A_LDIV): bus_rdata[LDIV_W-1:0] = ldiv_q;
      default: ;
    endcase
  end

  assign osc_sel    = src_q;
  assign pll_en     = pllc_q.en;
  assign pll_clk_en = pllc_q.clk_en;
  assign pll_imult  = mult_q.im;
  assign pll_fmult  = mult_q.fm;
  assign sys_div    = sdiv_q;
  assign aux_div    = adiv_q;
  assign clkout_div = odiv_q;
  assign lsp_div    = ldiv_q;

  // R5
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osc_sel) |-> (pll_imult == '0 && pll_fmult == '0 && !pll_en && !pll_clk_en));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[A_SDIV] |=> $stable(sys_div));

  // R4
  lock_hold_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[A_MULT] && !src_change) |=> $stable(mult_q));

  // R8
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc));
endmodule

// File: tb/tb_clkcfg_bank.sv
`timescale 1ns/1ps
module tb_clkcfg_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        pll_lock_i, pll_slip_i;
  logic [1:0]  osc_sel;
  logic        pll_en, pll_clk_en;
  logic [6:0]  pll_imult;
  logic [1:0]  pll_fmult;
  logic [5:0]  sys_div;
  logic [1:0]  aux_div, clkout_div;
  logic [2:0]  lsp_div;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] q_exp[$];
  logic [3:0]  q_adr[$];
  string       q_tag[$];
  event        mon_ev;

  always #2 clk = ~clk;

  clkcfg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_i(pll_lock_i),
    .pll_slip_i(pll_slip_i), .osc_sel(osc_sel), .pll_en(pll_en),
    .pll_clk_en(pll_clk_en), .pll_imult(pll_imult), .pll_fmult(pll_fmult),
    .sys_div(sys_div), .aux_div(aux_div), .clkout_div(clkout_div),
    .lsp_div(lsp_div)
  );

  // monitor: pops expected read items and compares
  initial begin
    forever begin
      @(mon_ev);
      while (q_exp.size() > 0) begin
        logic [15:0] e;
        logic [3:0]  a;
        string       t;
        e = q_exp.pop_front();
        a = q_adr.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %0d rdata=%h expected %h", t, a, bus_rdata, e);
        end
      end
    end
  end

  // each task starts just after a falling edge and consumes one cycle
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    bus_addr = a; bus_we = 1'b0;
    q_exp.push_back(e); q_adr.push_back(a); q_tag.push_back(t);
    #1;
    ->mon_ev;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_slip();
    pll_slip_i = 1'b1;
    @(negedge clk);
    pll_slip_i = 1'b0;
  endtask

  task automatic chk_port(input logic [15:0] act, input logic [15:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: port=%h expected %h", t, act, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pll_lock_i = 1'b0; pll_slip_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset values
    rd(0, 16'h0000, "R1 lock");
    rd(1, 16'h0000, "R1 src");
    rd(2, 16'h0000, "R1 pllctl");
    rd(3, 16'h0000, "R1 mult");
    rd(4, 16'h0000, "R1 status");
    rd(5, 16'h0002, "R1 sysdiv");
    rd(6, 16'h0001, "R1 auxdiv");
    rd(7, 16'h0003, "R1 outdiv");
    rd(8, 16'h0002, "R1 lspdiv");

    // R2 field layout and reserved bits
    wr(3, 16'hFF05);
    rd(3, 16'h0305, "R2 mult fields");
    chk_port({9'd0, pll_imult}, 16'h0005, "R2 imult port");
    chk_port({14'd0, pll_fmult}, 16'h0003, "R2 fmult port");
    wr(5, 16'hFFFF);
    rd(5, 16'h003F, "R2 reserved zero");

    // R7 write lost at t+69
    wr(8, 16'h0005);
    idle(68);
    wr(8, 16'h0001);
    rd(8, 16'h0005, "R7 lost at t+69");
    // R7 write accepted at t+70
    wr(6, 16'h0003);
    idle(69);
    wr(6, 16'h0000);
    rd(6, 16'h0000, "R7 accepted at t+70");

    // R8 independent windows
    wr(7, 16'h0001);
    wr(8, 16'h0006);
    rd(7, 16'h0001, "R8 first reg");
    rd(8, 16'h0006, "R8 second reg");

    // R3 / R4 locking
    wr(0, 16'h0080);
    rd(0, 16'h0080, "R3 lock set");
    idle(70);
    wr(7, 16'h0002);
    rd(7, 16'h0001, "R4 locked read");
    chk_port({14'd0, clkout_div}, 16'h0001, "R4 locked port");
    wr(0, 16'h0000);
    rd(0, 16'h0080, "R3 zero no effect");

    // R5 source change clearing
    idle(70);
    wr(2, 16'h0003);
    wr(3, 16'h0214);
    rd(2, 16'h0003, "R5 pllctl set");
    rd(3, 16'h0214, "R5 mult set");
    wr(1, 16'h0000);
    rd(3, 16'h0214, "R5 same src keeps mult");
    rd(2, 16'h0003, "R5 same src keeps pllctl");
    idle(70);
    wr(1, 16'h0002);
    rd(1, 16'h0002, "R5 src new");
    rd(3, 16'h0000, "R5 mult cleared");
    rd(2, 16'h0000, "R5 pllctl cleared");
    chk_port({9'd0, pll_imult}, 16'h0000, "R5 imult port");

    // R6 slip behaviour
    pll_lock_i = 1'b1;
    pulse_slip();
    rd(4, 16'h0001, "R6 no slip while bypassed");
    wr(2, 16'h0003);
    pulse_slip();
    rd(4, 16'h0003, "R6 slip set");
    wr(4, 16'h0000);
    rd(4, 16'h0003, "R9 status write ignored");
    idle(70);
    wr(2, 16'h0002);
    rd(4, 16'h0003, "R6 slip held after disable");
    idle(70);
    wr(2, 16'h0003);
    rd(4, 16'h0001, "R6 slip cleared on re-enable");

    // R9 unmapped
    wr(15, 16'hFFFF);
    rd(15, 16'h0000, "R9 unmapped read");
    rd(5, 16'h003F, "R9 unmapped write no effect");

    // R3 full lock, then reset
    wr(0, 16'hFFFF);
    rd(0, 16'h01EE, "R3 lock mask");
    wr(5, 16'h0001);
    rd(5, 16'h003F, "R4 sysdiv locked");
    do_reset();
    rd(0, 16'h0000, "R3 reset clears lock");
    rd(5, 16'h0002, "R1 sysdiv after reset");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule